// File: doc/BRIEF.md
# Per-Bit Read Deskew Edge Tracker

This block finds, for every data bit of one read strobe group, where that bit's valid capture window starts and ends. It does this in two delay sweeps. Each sweep step sets the delay outputs, asks an external read test to run, and takes back one pass bit per data lane. In the first sweep the shared data-input delay climbs from zero while the strobe delay stays at its starting value. In the second sweep the data delay returns to zero and the strobe delay climbs from its starting value. Signed left and right edge registers are kept for every bit. A value one above the largest data delay marks an edge that has not been found. A negative right edge, written as -(d+1), stands for a provisional edge seen before any pass.

A sticky vector collects every lane that has passed so far. A sweep ends early only when a test fails on all lanes and the sticky vector is already full. Between the two sweeps, provisional right edges on bits that never passed are cleared. The sticky vector is then reloaded with the bits that hold two real edges. An optional mode makes the strobe-enable delay follow the strobe delay, capped at its own maximum. Software reads the results back through an indexed port once `done` is high.

The test link is two handshakes. A request is offered with `req_valid`. It stays up, with every delay output frozen, until the tester raises `req_ready`. The block then raises `res_ready` and waits as long as needed for `res_valid`. Either side may stall for any number of cycles.

Top module: `deskew_edge_tracker`

## Requirements
- R1: On reset, and on a `start` accepted while idle or done, every left and right edge becomes the sentinel DQ_MAX+1 and the sticky vector becomes zero. `start` is ignored while `busy` is high.
- R2: `req_valid` holds, with `dq_dly`, `dqs_dly` and `en_dly` unchanged, until it is accepted by `req_ready`. `res_ready` is high only after a request is accepted and before its result arrives. A test counts as failed when `res_pass` is all zeros.
- R3: Every accepted pass vector is ORed into the sticky vector. A sweep ends on a failed test while the sticky vector is all ones, and that test changes no edge. With a lane that never passes, both sweeps run to their last step.
- R4: The first sweep presents `dq_dly` = 0, 1, ... DQ_MAX with `dqs_dly` at the latched start value. Each passing bit writes the current step into its left edge.
- R5: In the first sweep, a failing bit whose left edge is still the sentinel gets the right edge -(d+1).
- R6: Between the sweeps, a bit whose left edge is the sentinel gets its right edge set back to the sentinel. The sticky vector is rebuilt as 1 only for bits whose two edges are both non-sentinel, and `dq_dly` returns to 0.
- R7: The second sweep presents `dqs_dly` = start + d for d = 0 .. DQS_MAX-start. If the start value is above DQS_MAX, the second sweep issues no test.
- R8: In the second sweep, each passing bit writes d into its right edge.
- R9: With EN_SHIFT set, `en_dly` = min(en_start + (dqs_dly - start), EN_MAX). With EN_SHIFT clear, it stays at `en_start`.
- R10: `done` rises when the last sweep ends and stays high, with `req_valid` low, until the next `start`. `rd_left`/`rd_right` give bit `rd_idx`'s edges as EW-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a two-sweep search (ignored while busy) |
| dqs_start | input | SW | Starting strobe delay, latched at start |
| en_start | input | ENW | Starting strobe-enable delay, latched at start |
| req_valid | output | 1 | Test request offered |
| req_ready | input | 1 | Tester accepts the request |
| res_valid | input | 1 | Test result present |
| res_ready | output | 1 | Block waits for a result |
| res_pass | input | NBITS | Per-lane pass vector, 1 = pass |
| dq_dly | output | DQW | Shared data-input delay setting |
| dqs_dly | output | SW | Strobe-input delay setting |
| en_dly | output | ENW | Strobe-enable delay setting |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, results valid |
| rd_idx | input | IW | Bit selected on the read port |
| rd_left | output | EW | Left edge of the selected bit, signed |
| rd_right | output | EW | Right edge of the selected bit, signed |

## Verification
The bench builds the block with four lanes, DQ_MAX 7, DQS_MAX 6 and EN_MAX 5, with enable following on. A three-bit strobe start can therefore exceed DQS_MAX, so the empty second sweep can be driven. A start of exactly DQS_MAX gives a one-step second sweep, and an enable start of 4 hits the clamp after one strobe step. The emulated tester makes each lane pass when the difference between the strobe and data delays falls in that lane's window. This lets one window set produce negative provisional edges, early stops in both sweeps, and a lane that never passes, which forces full-length sweeps. The tester also inserts stalls on both handshakes.

// File: rtl/dskw_pkg.sv
package dskw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_FIX,
    ST_DONE
  } dskw_state_t;
endpackage

// File: rtl/dskw_ctrl.sv
module dskw_ctrl #(
  parameter int DQ_MAX  = 31,
  parameter int DQS_MAX = 31,
  parameter int DQW     = 5,
  parameter int SW      = 5,
  parameter int EW      = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [SW-1:0]        dqs_start,
  output logic                 req_valid,
  input  logic                 req_ready,
  input  logic                 res_valid,
  output logic                 res_ready,
  input  logic                 res_fail,
  input  logic                 sticky_full,
  output logic [DQW-1:0]       dq_dly,
  output logic [SW-1:0]        dqs_ofs,
  output logic [SW-1:0]        dqs_dly,
  output logic                 busy,
  output logic                 done,
  output logic                 init,
  output logic                 upd,
  output logic                 fix,
  output logic                 ph2,
  output logic signed [EW-1:0] step
);
  import dskw_pkg::*;

  localparam logic [DQW-1:0] DQ_LAST = DQW'(DQ_MAX);
  localparam logic [SW:0]    DQS_TOP = (SW+1)'(DQS_MAX);

  dskw_state_t state;
  logic [DQW-1:0] d1;
  logic [SW-1:0]  d2, base;
  logic accept, stop, last1, last2;

  assign accept = (state == ST_WAIT) && res_valid;
  assign stop   = res_fail && sticky_full;
  assign last1  = (d1 == DQ_LAST);
  assign last2  = (({1'b0, base} + {1'b0, d2}) == DQS_TOP);

  assign init      = start && ((state == ST_IDLE) || (state == ST_DONE));
  assign upd       = accept && !stop;
  assign fix       = (state == ST_FIX);
  assign req_valid = (state == ST_REQ);
  assign res_ready = (state == ST_WAIT);
  assign busy      = (state == ST_REQ) || (state == ST_WAIT) || (state == ST_FIX);
  assign done      = (state == ST_DONE);
  assign dq_dly    = d1;
  assign dqs_ofs   = d2;
  assign dqs_dly   = base + d2;
  assign step      = ph2 ? EW'({1'b0, d2}) : EW'({1'b0, d1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      d1    <= '0;
      d2    <= '0;
      base  <= '0;
      ph2   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: if (start) begin
          state <= ST_REQ;
          d1    <= '0;
          d2    <= '0;
          ph2   <= 1'b0;
          base  <= dqs_start;
        end
        ST_REQ: if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (res_valid) begin
          if (!ph2) begin
            if (stop || last1) state <= ST_FIX;
            else begin
              d1    <= d1 + 1'b1;
              state <= ST_REQ;
            end
          end else begin
            if (stop || last2) state <= ST_DONE;
            else begin
              d2    <= d2 + 1'b1;
              state <= ST_REQ;
            end
          end
        end
        ST_FIX: begin
          d1 <= '0;
          d2 <= '0;
          if ({1'b0, base} > DQS_TOP) state <= ST_DONE;
          else begin
            ph2   <= 1'b1;
            state <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(dq_dly) && $stable(dqs_dly)));

  assert_stop_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && stop && !ph2) |=> fix);

  assert_dq_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2 && busy) |-> (dq_dly == '0));

  assert_dqs_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2 && req_valid) |-> ({1'b0, dqs_dly} <= DQS_TOP));

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && !req_valid));
endmodule

// File: rtl/dskw_edge_bank.sv
module dskw_edge_bank #(
  parameter int NBITS = 8,
  parameter int EW    = 7,
  parameter int SENT  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init,
  input  logic                  upd,
  input  logic                  fix,
  input  logic                  ph2,
  input  logic signed [EW-1:0]  step,
  input  logic [NBITS-1:0]      pass,
  output logic [NBITS-1:0]      sticky,
  output logic [NBITS*EW-1:0]   left_flat,
  output logic [NBITS*EW-1:0]   right_flat
);
  localparam logic signed [EW-1:0] S = EW'(SENT);

  logic [NBITS-1:0] both_ok;

  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    logic signed [EW-1:0] lq, rq;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lq <= S;
        rq <= S;
      end else if (init) begin
        lq <= S;
        rq <= S;
      end else if (fix) begin
        if (lq == S && rq != S) rq <= S;
      end else if (upd) begin
        if (!ph2) begin
          if (pass[g]) lq <= step;
          else if (lq == S) rq <= ~step;  // ~d equals -(d+1)
        end else if (pass[g]) begin
          rq <= step;
        end
      end
    end

    assign both_ok[g] = (lq != S) && (rq != S);
    assign left_flat[g*EW +: EW]  = lq;
    assign right_flat[g*EW +: EW] = rq;

    assert_left_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lq >= 0);

    assert_fix_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fix |=> ((lq != S) || (rq == S)));

    assert_pass_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && ph2 && pass[g]) |=> (rq == $past(step)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sticky <= '0;
    else if (init)  sticky <= '0;
    else if (fix)   sticky <= both_ok;
    else if (upd)   sticky <= sticky | pass;
  end

  assert_sticky_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ((sticky & $past(pass)) == $past(pass)));

  assert_init_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (sticky == '0));
endmodule

// File: rtl/dskw_en_track.sv
module dskw_en_track #(
  parameter bit SHIFT  = 1'b1,
  parameter int EN_MAX = 31,
  parameter int ENW    = 5,
  parameter int SW     = 5
) (
  input  logic [ENW-1:0] base,
  input  logic [SW-1:0]  ofs,
  output logic [ENW-1:0] en_dly
);
  localparam int SUMW = ((ENW > SW) ? ENW : SW) + 1;

  if (SHIFT) begin : g_follow
    logic [SUMW-1:0] sum;
    assign sum    = SUMW'(base) + SUMW'(ofs);
    assign en_dly = (sum > SUMW'(EN_MAX)) ? ENW'(EN_MAX) : sum[ENW-1:0];
  end else begin : g_hold
    logic unused_ofs;
    assign unused_ofs = ^ofs;
    assign en_dly     = base;
  end
endmodule

// File: rtl/deskew_edge_tracker.sv
module deskew_edge_tracker #(
  parameter int NBITS    = 8,
  parameter int DQ_MAX   = 31,
  parameter int DQS_MAX  = 31,
  parameter int EN_MAX   = 31,
  parameter bit EN_SHIFT = 1'b1,
  parameter int DQW      = $clog2(DQ_MAX + 1),
  parameter int SW       = $clog2(DQS_MAX + 1),
  parameter int ENW      = $clog2(EN_MAX + 1),
  parameter int IW       = (NBITS > 1) ? $clog2(NBITS) : 1,
  parameter int EW       = $clog2(((DQ_MAX + 1 > DQS_MAX) ? DQ_MAX + 1 : DQS_MAX) + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SW-1:0]    dqs_start,
  input  logic [ENW-1:0]   en_start,
  output logic             req_valid,
  input  logic             req_ready,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [NBITS-1:0] res_pass,
  output logic [DQW-1:0]   dq_dly,
  output logic [SW-1:0]    dqs_dly,
  output logic [ENW-1:0]   en_dly,
  output logic             busy,
  output logic             done,
  input  logic [IW-1:0]    rd_idx,
  output logic [EW-1:0]    rd_left,
  output logic [EW-1:0]    rd_right
);
  localparam int SENT = DQ_MAX + 1;

  logic init, upd, fix, ph2;
  logic signed [EW-1:0] step;
  logic [SW-1:0] dqs_ofs;
  logic [NBITS-1:0] sticky;
  logic [NBITS*EW-1:0] lflat, rflat;
  logic [ENW-1:0] en_base;
  logic [EW-1:0] l_arr [NBITS];
  logic [EW-1:0] r_arr [NBITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_base <= '0;
    else if (init) en_base <= en_start;
  end

  dskw_ctrl #(
    .DQ_MAX(DQ_MAX), .DQS_MAX(DQS_MAX), .DQW(DQW), .SW(SW), .EW(EW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .dqs_start(dqs_start),
    .req_valid(req_valid), .req_ready(req_ready),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_fail(~|res_pass), .sticky_full(&sticky),
    .dq_dly(dq_dly), .dqs_ofs(dqs_ofs), .dqs_dly(dqs_dly),
    .busy(busy), .done(done), .init(init), .upd(upd), .fix(fix),
    .ph2(ph2), .step(step)
  );

  dskw_edge_bank #(
    .NBITS(NBITS), .EW(EW), .SENT(SENT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .init(init), .upd(upd), .fix(fix),
    .ph2(ph2), .step(step), .pass(res_pass), .sticky(sticky),
    .left_flat(lflat), .right_flat(rflat)
  );

  dskw_en_track #(
    .SHIFT(EN_SHIFT), .EN_MAX(EN_MAX), .ENW(ENW), .SW(SW)
  ) u_en (
    .base(en_base), .ofs(dqs_ofs), .en_dly(en_dly)
  );

  for (genvar g = 0; g < NBITS; g++) begin : g_rd
    assign l_arr[g] = lflat[g*EW +: EW];
    assign r_arr[g] = rflat[g*EW +: EW];
  end

  always_comb begin
    rd_left  = '0;
    rd_right = '0;
    if (32'(rd_idx) < NBITS) begin
      rd_left  = l_arr[rd_idx];
      rd_right = r_arr[rd_idx];
    end
  end

  assert_en_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, en_dly} <= (ENW+1)'(EN_MAX)) || !EN_SHIFT);

  assert_en_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $stable(dqs_dly) && !$past(init)) |-> $stable(en_dly));
endmodule

// File: tb/sim_deskew_edge_tracker.sv
module sim_deskew_edge_tracker;
  localparam int CLK_NS = 10;
  localparam int NB = 4, DQM = 7, DQSM = 6, ENM = 5;
  localparam int S = DQM + 1;
  localparam int EWB = 5;

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] dqs_start = 0, en_start = 0;
  logic req_valid, req_ready = 0, res_valid = 0, res_ready;
  logic [NB-1:0] res_pass = 0;
  logic [2:0] dq_dly, dqs_dly, en_dly;
  logic busy, done;
  logic [1:0] rd_idx = 0;
  logic [EWB-1:0] rd_left, rd_right;

  deskew_edge_tracker #(.NBITS(NB), .DQ_MAX(DQM), .DQS_MAX(DQSM), .EN_MAX(ENM),
    .EN_SHIFT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dqs_start(dqs_start), .en_start(en_start),
    .req_valid(req_valid), .req_ready(req_ready), .res_valid(res_valid),
    .res_ready(res_ready), .res_pass(res_pass), .dq_dly(dq_dly), .dqs_dly(dqs_dly),
    .en_dly(en_dly), .busy(busy), .done(done), .rd_idx(rd_idx),
    .rd_left(rd_left), .rd_right(rd_right));

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int lo [NB], hi [NB];
  int exp_l [NB], exp_r [NB], exp_tests;
  int s_cur = 0, en_cur = 0, tests_seen = 0, seed = 5;
  bit stall_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [NB-1:0] pass_vec(input int dqs, input int dq);
    int k = dqs - dq + 8;
    for (int i = 0; i < NB; i++) pass_vec[i] = (k >= lo[i]) && (k <= hi[i]);
  endfunction

  function automatic int stall_len();
    seed = (seed * 13 + 7) % 101;
    return stall_on ? seed % 3 : 0;
  endfunction

  // tester: answers every request, checks handshake and enable tracking
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        int a_dq, a_dqs, ee;
        repeat (stall_len()) @(negedge clk);
        a_dq = dq_dly; a_dqs = dqs_dly;
        ee = en_cur + (a_dqs - s_cur);
        if (ee > ENM) ee = ENM;
        chk(en_dly == ee, "R9 en_dly", en_dly, ee);
        req_ready = 1; @(negedge clk); req_ready = 0;
        repeat (stall_len()) @(negedge clk);
        chk(res_ready == 1, "R2 res_ready", res_ready, 1);
        chk(dq_dly == a_dq && dqs_dly == a_dqs, "R2 delays held", dqs_dly, a_dqs);
        res_pass = pass_vec(dqs_dly, dq_dly); res_valid = 1;
        @(negedge clk); res_valid = 0; tests_seen++;
      end
    end
  end

  task automatic model(input int s);
    int st = 0, full = (1 << NB) - 1;
    logic [NB-1:0] pv;
    exp_tests = 0;
    for (int i = 0; i < NB; i++) begin exp_l[i] = S; exp_r[i] = S; end
    for (int d = 0; d <= DQM; d++) begin
      pv = pass_vec(s, d); exp_tests++;
      if (pv == 0 && st == full) break;
      st |= pv;
      for (int i = 0; i < NB; i++)
        if (pv[i]) exp_l[i] = d; else if (exp_l[i] == S) exp_r[i] = -(d + 1);
    end
    st = 0;
    for (int i = 0; i < NB; i++) begin
      if (exp_l[i] == S) exp_r[i] = S;
      if (exp_l[i] != S && exp_r[i] != S) st |= (1 << i);
    end
    if (s <= DQSM)
      for (int d = 0; d <= DQSM - s; d++) begin
        pv = pass_vec(s + d, 0); exp_tests++;
        if (pv == 0 && st == full) break;
        st |= pv;
        for (int i = 0; i < NB; i++) if (pv[i]) exp_r[i] = d;
      end
  endtask

  task automatic do_run(input int s, input int e, input bit poke, input string tag);
    int n = 0;
    model(s);
    s_cur = s; en_cur = e; tests_seen = 0;
    @(negedge clk); dqs_start = 3'(s); en_start = 3'(e); start = 1;
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(busy == 1, "R1 busy before poke", busy, 1);
      dqs_start = 0; start = 1; @(negedge clk); start = 0;
    end
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done == 1, {tag, " R10 done"}, done, 1);
    chk(tests_seen == exp_tests, {tag, " R3 test count"}, tests_seen, exp_tests);
    for (int i = 0; i < NB; i++) begin
      rd_idx = 2'(i); #1;
      chk(int'($signed(rd_left)) == exp_l[i], {tag, " R4 left edge"}, int'($signed(rd_left)), exp_l[i]);
      chk(int'($signed(rd_right)) == exp_r[i], {tag, " R5/R8 right edge"}, int'($signed(rd_right)), exp_r[i]);
    end
    if (s <= DQSM) chk(dq_dly == 0, {tag, " R6 dq reset"}, dq_dly, 0);
  endtask

  task automatic set_win(input int l0, h0, l1, h1, l2, h2, l3, h3);
    lo[0] = l0; hi[0] = h0; lo[1] = l1; hi[1] = h1;
    lo[2] = l2; hi[2] = h2; lo[3] = l3; hi[3] = h3;
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0, "R1 idle after reset", busy, 0);
    chk(req_valid == 0, "R2 no request after reset", req_valid, 0);
    rd_idx = 0; #1;
    chk(int'($signed(rd_left)) == S, "R1 left sentinel", int'($signed(rd_left)), S);
    chk(int'($signed(rd_right)) == S, "R1 right sentinel", int'($signed(rd_right)), S);
  endtask

  task automatic t_provisional();   // negative edges, cleanup, sweep-2 stop
    set_win(5, 11, 4, 12, 6, 13, 3, 10);
    do_run(5, 0, 0, "prov");
    chk(tests_seen == 10, "R3 prov stop count", tests_seen, 10);
  endtask

  task automatic t_early_stop();    // sweep-1 ends before DQ_MAX
    set_win(9, 13, 10, 13, 9, 12, 8, 13);
    do_run(5, 1, 0, "early");
  endtask

  task automatic t_dead_lane();     // sticky never full: full sweeps
    set_win(5, 11, 4, 12, 6, 13, 99, 0);
    do_run(2, 4, 0, "dead");
    chk(tests_seen == 13, "R3 full sweeps", tests_seen, 13);
    chk(en_dly == ENM, "R9 enable clamp", en_dly, ENM);
  endtask

  task automatic t_high_start();
    set_win(5, 11, 4, 12, 6, 13, 99, 0);
    do_run(7, 2, 0, "high");
    chk(tests_seen == 8, "R7 no second sweep", tests_seen, 8);
    chk(dqs_dly == 7, "R7 strobe held", dqs_dly, 7);
  endtask

  task automatic t_top_start();
    set_win(5, 11, 4, 12, 6, 13, 99, 0);
    do_run(6, 3, 0, "top");
    chk(tests_seen == 9, "R7 single step", tests_seen, 9);
  endtask

  task automatic t_stall_poke();
    stall_on = 1;
    set_win(5, 11, 4, 12, 6, 13, 3, 10);
    do_run(3, 4, 1, "stall");
    stall_on = 0;
  endtask

  task automatic t_done_hold();
    repeat (5) @(negedge clk);
    chk(done == 1 && req_valid == 0, "R10 done held", done, 1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_provisional();
    t_early_stop();
    t_dead_lane();
    t_high_start();
    t_top_start();
    t_stall_poke();
    t_done_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule